// File: doc/BRIEF.md
# Dual-Mode Tick Timer with Timestamp

This unit supplies an operating system with two time services. A 32-bit timestamp counter advances by one on every clock and can be read at any moment. A single down-counting tick timer produces a periodic or a single timed event. The tick timer holds its reload count and its two mode options in one register. The reload count sits in the upper bits. An enable option and a one-shot option sit in the lowest two bits.

When the countdown runs out, the unit sets a pending flag and drives the interrupt output high. In periodic mode the counter refills from the reload count and keeps running. In one-shot mode the timer turns itself off by clearing its own enable option. Software acknowledges an event by writing a one to the pending bit.

The tick timer is a two-state machine. In **TMR_OFF** the counter holds its value. In **TMR_COUNT** it counts down by one per cycle. The named transitions are:
- **ARM** (TMR_OFF to TMR_COUNT): a reload write with enable set.
- **TICK** (TMR_COUNT to TMR_COUNT): the count is non-zero and is decremented.
- **REFILL** (TMR_COUNT to TMR_COUNT): a periodic expiry.
- **RESTART** (TMR_COUNT to TMR_COUNT): a reload write with enable set while the timer runs.
- **SINGLE_DONE** (TMR_COUNT to TMR_OFF): a one-shot expiry.
- **DISARM** (TMR_COUNT to TMR_OFF): a reload write with enable clear.

Top module: `ostm_timer_unit`

## Requirements
- R1: The timestamp counter increases by one every clock cycle and wraps from 0xFFFFFFFF to 0. Address 0 reads its present value.
- R2: A write to address 0 loads the write data into the timestamp counter, so writing zero resets it. Counting resumes from that value on the next cycle.
- R3: Address 1 is the reload register, and it reads back as written. Bit 0 is enable and bit 1 is one-shot. The reload count N is the written value with bits 1:0 forced to zero. A write with enable set loads the counter with N at the write edge. The first expiry sets pending N+1 cycles after that edge.
- R4: In periodic mode (bit 1 clear), expiries repeat every N+1 cycles.
- R5: In one-shot mode (bit 1 set), the timer expires once. It then clears bit 0 of the reload register, and no further expiry occurs.
- R6: A reload write with bit 0 clear, including an all-zero write, stops the timer. No expiry follows.
- R7: Address 2 bit 0 is the pending flag. Writing 1 to that bit clears it, and writing 0 leaves it unchanged. An expiry in the same cycle as a clear leaves the flag set.
- R8: The interrupt output follows the pending flag. It stays high across further expiries until software clears the flag.
- R9: A reload write with enable set while the timer runs restarts the countdown from the new reload count.
- R10: After reset, the timestamp, the reload register and the pending flag are all zero, and the interrupt output is low.
- R11: Address 3 reads as zero, and writes to it have no effect on any other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address (0 timestamp, 1 reload, 2 status, 3 unused) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Interrupt, high while the pending flag is set |

## Verification
A wrong count or a wrong state in the tick machine first becomes visible as a pending flag that rises one or more cycles early or late. The bench therefore reads the status register exactly one cycle before and one cycle after each predicted expiry. A one-shot machine that fails to stop shows up within one reload period, either as a second rise of the flag or as the enable bit still reading 1. A lost reset or a missing increment in the timestamp shows at the very next read of address 0.

// File: rtl/ostm_pkg.sv
package ostm_pkg;
    localparam int unsigned TS_W   = 32;
    localparam int unsigned OPT_W  = 2;
    localparam int unsigned ADDR_W = 2;

    localparam int unsigned OPT_EN  = 0;
    localparam int unsigned OPT_ONE = 1;

    localparam logic [ADDR_W-1:0] A_TSTAMP = 2'd0;
    localparam logic [ADDR_W-1:0] A_RELOAD = 2'd1;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd2;

    typedef enum logic {
        TMR_OFF   = 1'b0,
        TMR_COUNT = 1'b1
    } tmr_state_t;
endpackage

// File: rtl/ostm_timestamp.sv
module ostm_timestamp #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] ts
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            ts <= '0;
        else if (load)
            ts <= load_val;
        else
            ts <= ts + W'(1);
    end
endmodule

// File: rtl/ostm_tick.sv
module ostm_tick
    import ostm_pkg::*;
#(
    parameter int unsigned W    = 32,
    parameter int unsigned OPTS = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] reload_q,
    output logic [W-1:0] count,
    output tmr_state_t   state,
    output logic         expire
);
    localparam logic [W-1:0] OPT_MASK = W'((1 << OPTS) - 1);

    tmr_state_t  next_state;
    logic [W-1:0] reload_val;

    assign reload_val = reload_q & ~OPT_MASK;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= TMR_OFF;
        else
            state <= next_state;
    end

    // Next state and expiry
    always_comb begin
        expire     = (state == TMR_COUNT) && (count == '0) && !wr;
        next_state = state;
        unique case (state)
            TMR_OFF: begin
                if (wr && wdata[OPT_EN])
                    next_state = TMR_COUNT;                 // ARM
            end
            TMR_COUNT: begin
                if (wr)
                    next_state = wdata[OPT_EN] ? TMR_COUNT  // RESTART
                                               : TMR_OFF;   // DISARM
                else if (expire && reload_q[OPT_ONE])
                    next_state = TMR_OFF;                   // SINGLE_DONE
                else
                    next_state = TMR_COUNT;                 // TICK / REFILL
            end
            default: next_state = TMR_OFF;
        endcase
    end

    // Down-counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (wr && wdata[OPT_EN])
            count <= wdata & ~OPT_MASK;
        else if (state == TMR_COUNT && !wr) begin
            if (count == '0)
                count <= reload_val;
            else
                count <= count - W'(1);
        end
    end

    // Reload register; one-shot expiry drops its own enable
    always_ff @(posedge clk) begin
        if (!rst_n)
            reload_q <= '0;
        else if (wr)
            reload_q <= wdata;
        else if (expire && reload_q[OPT_ONE])
            reload_q[OPT_EN] <= 1'b0;
    end
endmodule

// File: rtl/ostm_status.sv
module ostm_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (set)
            pend <= 1'b1;
        else if (clr)
            pend <= 1'b0;
    end
endmodule

// File: rtl/ostm_timer_unit.sv
module ostm_timer_unit
    import ostm_pkg::*;
#(
    parameter int unsigned W = TS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    output logic              irq
);
    logic         ts_wr, rl_wr, st_clr;
    logic [W-1:0] ts_val, reload_q, tmr_count;
    tmr_state_t   tmr_state;
    logic         tmr_expire, pend;

    assign ts_wr  = reg_wen && (reg_addr == A_TSTAMP);
    assign rl_wr  = reg_wen && (reg_addr == A_RELOAD);
    assign st_clr = reg_wen && (reg_addr == A_STATUS) && reg_wdata[0];

    ostm_timestamp #(.W(W)) u_ts (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ts_wr),
        .load_val (reg_wdata),
        .ts       (ts_val)
    );

    ostm_tick #(.W(W), .OPTS(OPT_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (rl_wr),
        .wdata    (reg_wdata),
        .reload_q (reload_q),
        .count    (tmr_count),
        .state    (tmr_state),
        .expire   (tmr_expire)
    );

    ostm_status u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (tmr_expire),
        .clr   (st_clr),
        .pend  (pend)
    );

    always_comb begin
        unique case (reg_addr)
            A_TSTAMP: reg_rdata = ts_val;
            A_RELOAD: reg_rdata = reload_q;
            A_STATUS: reg_rdata = {{(W-1){1'b0}}, pend};
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = pend;
endmodule

// File: rtl/ostm_timer_unit_chk.sv
module ostm_timer_unit_chk
    import ostm_pkg::*;
#(
    parameter int unsigned W = TS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wen,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [W-1:0]      reg_wdata,
    input logic [W-1:0]      ts_val,
    input logic [W-1:0]      reload_q,
    input logic [W-1:0]      tmr_count,
    input tmr_state_t        tmr_state,
    input logic              irq
);
    logic         rw, tw, clr, run_zero;
    logic [W-1:0] nval;

    assign rw       = reg_wen && (reg_addr == A_RELOAD);
    assign tw       = reg_wen && (reg_addr == A_TSTAMP);
    assign clr      = reg_wen && (reg_addr == A_STATUS) && reg_wdata[0];
    assign run_zero = (tmr_state == TMR_COUNT) && (tmr_count == '0) && !rw;
    assign nval     = {reload_q[W-1:OPT_W], {OPT_W{1'b0}}};

    p_ts_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tw |=> ts_val == $past(ts_val) + W'(1));

    p_ts_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tw |=> ts_val == $past(reg_wdata));

    p_count_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_state == TMR_COUNT && tmr_count != '0 && !rw) |=>
            (tmr_count == $past(tmr_count) - W'(1)) && tmr_state == TMR_COUNT);

    p_refill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_zero && !reload_q[OPT_ONE]) |=>
            (tmr_count == $past(nval)) && tmr_state == TMR_COUNT && irq);

    p_single_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_zero && reload_q[OPT_ONE]) |=>
            tmr_state == TMR_OFF && !reload_q[OPT_EN] && irq);

    p_off_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_state == TMR_OFF && !rw) |=> tmr_state == TMR_OFF && $stable(tmr_count));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !run_zero) |=> !irq);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> irq);

    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rw && reg_wdata[OPT_EN]) |=>
            tmr_state == TMR_COUNT && tmr_count == {$past(reg_wdata[W-1:OPT_W]), {OPT_W{1'b0}}});
endmodule

bind ostm_timer_unit ostm_timer_unit_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wen   (reg_wen),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ts_val    (ts_val),
    .reload_q  (reload_q),
    .tmr_count (tmr_count),
    .tmr_state (tmr_state),
    .irq       (irq)
);

// File: tb/ostm_timer_unit_test.sv
`timescale 1ns/1ps
module ostm_timer_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    ostm_timer_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wen   (reg_wen),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_WT = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  addr;
        logic [31:0] data;   // write data, wait count, or expected read value
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 41;
    localparam vec_t VEC [NV] = '{
        '{OP_WR, 2'd1, 32'h11, 8'd3},   // R3 periodic, N=16
        '{OP_RD, 2'd1, 32'h11, 8'd3},   // R3 readback
        '{OP_WT, 2'd0, 32'd16, 8'd3},
        '{OP_RD, 2'd2, 32'd0,  8'd3},   // R3 one cycle before expiry
        '{OP_WT, 2'd0, 32'd1,  8'd3},
        '{OP_RD, 2'd2, 32'd1,  8'd3},   // R3 expiry at N+1
        '{OP_WR, 2'd2, 32'd1,  8'd7},   // R7 clear
        '{OP_RD, 2'd2, 32'd0,  8'd7},
        '{OP_WT, 2'd0, 32'd15, 8'd4},
        '{OP_RD, 2'd2, 32'd0,  8'd4},   // R4 before second expiry
        '{OP_WT, 2'd0, 32'd1,  8'd4},
        '{OP_RD, 2'd2, 32'd1,  8'd4},   // R4 second expiry
        '{OP_WR, 2'd2, 32'd0,  8'd7},   // R7 write 0 no effect
        '{OP_RD, 2'd2, 32'd1,  8'd7},
        '{OP_WR, 2'd1, 32'd0,  8'd6},   // R6 disable
        '{OP_WR, 2'd2, 32'd1,  8'd6},
        '{OP_WT, 2'd0, 32'd40, 8'd6},
        '{OP_RD, 2'd2, 32'd0,  8'd6},   // R6 no expiry
        '{OP_RD, 2'd1, 32'd0,  8'd6},
        '{OP_WR, 2'd1, 32'h13, 8'd5},   // R5 one-shot N=16
        '{OP_WT, 2'd0, 32'd16, 8'd5},
        '{OP_RD, 2'd2, 32'd0,  8'd5},
        '{OP_WT, 2'd0, 32'd1,  8'd5},
        '{OP_RD, 2'd2, 32'd1,  8'd5},
        '{OP_RD, 2'd1, 32'h12, 8'd5},   // R5 enable self-cleared
        '{OP_WR, 2'd2, 32'd1,  8'd5},
        '{OP_WT, 2'd0, 32'd40, 8'd5},
        '{OP_RD, 2'd2, 32'd0,  8'd5},   // R5 no second expiry
        '{OP_WR, 2'd1, 32'h21, 8'd9},   // R9 N=32
        '{OP_WT, 2'd0, 32'd10, 8'd9},
        '{OP_WR, 2'd1, 32'h11, 8'd9},   // R9 restart with N=16
        '{OP_WT, 2'd0, 32'd16, 8'd9},
        '{OP_RD, 2'd2, 32'd0,  8'd9},
        '{OP_WT, 2'd0, 32'd1,  8'd9},
        '{OP_RD, 2'd2, 32'd1,  8'd9},
        '{OP_WR, 2'd1, 32'd0,  8'd9},
        '{OP_WR, 2'd2, 32'd1,  8'd9},
        '{OP_WR, 2'd3, 32'hFFFF_FFFF, 8'd11}, // R11 unused address
        '{OP_RD, 2'd3, 32'd0,  8'd11},
        '{OP_RD, 2'd1, 32'd0,  8'd11},
        '{OP_RD, 2'd2, 32'd0,  8'd11}
    };

    task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wen   = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wen   = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic rd(input int req, input logic [1:0] a, input logic [31:0] exp);
        reg_addr = a;
        #0.5;
        chk(req, reg_rdata, exp);
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        rd(10, 2'd0, 32'd0);
        rd(10, 2'd1, 32'd0);
        rd(10, 2'd2, 32'd0);
        chk(10, {31'd0, irq}, 32'd0);

        // R1 increment
        reg_addr = 2'd0; #0.5; t0 = reg_rdata;
        @(negedge clk);
        rd(1, 2'd0, t0 + 32'd1);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            unique case (VEC[i].op)
                OP_WR:   wr(VEC[i].addr, VEC[i].data);
                OP_RD:   rd(int'(VEC[i].req), VEC[i].addr, VEC[i].data);
                default: wt(int'(VEC[i].data));
            endcase
        end

        // R2 load and R1 wrap
        wr(2'd0, 32'hFFFF_FFF0);
        rd(2, 2'd0, 32'hFFFF_FFF0);
        wt(16);
        rd(1, 2'd0, 32'd0);
        wt(3);
        wr(2'd0, 32'd0);
        rd(2, 2'd0, 32'd0);

        // R8 interrupt follows and holds
        wr(2'd1, 32'h11);
        wt(17);
        chk(8, {31'd0, irq}, 32'd1);
        wt(30);
        chk(8, {31'd0, irq}, 32'd1);

        // R7 same-cycle expiry and clear
        wr(2'd1, 32'd0);
        wr(2'd2, 32'd1);
        rd(7, 2'd2, 32'd0);
        wr(2'd1, 32'h11);
        wt(16);
        wr(2'd2, 32'd1);
        rd(7, 2'd2, 32'd1);
        chk(8, {31'd0, irq}, 32'd1);
        wr(2'd1, 32'd0);
        wr(2'd2, 32'd1);
        chk(8, {31'd0, irq}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule